// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives serial-clock timing for a synchronous serial shifter from the system clock. Two independent channels are built: one for transmit and one for receive. Each channel has its own 16-bit scale word, loaded through a simple write strobe with a channel select.

The scale word holds two fields. The first is a 5-bit linear multiplier. The second is a 3-bit shift code that picks a power of two. The serial clock period is the product of (multiplier + 1) and the power of two, and one shift code bypasses to the fastest rate. Software chooses the code; the block does not search for a divisor.

Each channel outputs an SCK level and two one-cycle strobes for the shift engine. The leading strobe marks the edge away from the idle level and the trailing strobe marks the return to idle. A shared enable gates both channels, and a shared polarity input sets the idle level. A new scale word is applied only at a half-period boundary, so a reprogram never creates a short pulse.

Top module: `spi_baud_div`

## Requirements
- R1: After reset with the enable low, both SCK outputs equal the polarity input and all four strobes are low.
- R2: A write with `wr_sel_i` = 0 loads the transmit scale word and a write with `wr_sel_i` = 1 loads the receive one. The multiplier is taken from bits 12:8 and the shift code from bits 2:0; all other bits are ignored.
- R3: For shift codes 0 to 4, every SCK half-period lasts (multiplier+1)·2^code system clocks. The full period is twice that, giving ratios 2, 4, 8, 16 and 32 for multiplier 0, and 1024 at most (multiplier 31, code 4).
- R4: Shift code 7 is a bypass. SCK toggles on every enabled clock whatever the multiplier holds, and the leading and trailing strobes alternate on consecutive cycles.
- R5: Reserved shift codes 5 and 6 give the same timing as code 4.
- R6: While the enable is low, SCK holds the polarity level, no strobe fires and the counters are cleared. The first toggle after the enable rises comes one half-period of enabled clocks later, and a drop of the enable returns SCK to idle on the next clock.
- R7: The leading strobe is high for exactly the one cycle in which SCK first shows the non-idle level. The trailing strobe is high for the one cycle in which SCK first returns to the idle level. The two strobes are never high together, and no strobe fires between toggles.
- R8: With the polarity input at 1, the idle SCK level is 1 and the leading edge is the falling edge.
- R9: A scale word written during a half-period does not change the length of that half-period. It governs every half-period from the next boundary on.
- R10: The transmit and receive channels keep independent timing. A write to one channel does not alter the other.
- R11: The high and low phases of SCK have equal length, which gives a 50% duty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_en_i | input | 1 | Clock enable for both channels |
| cpol_i | input | 1 | Idle level of SCK |
| wr_en_i | input | 1 | Scale word write strobe |
| wr_sel_i | input | 1 | Write target: 0 transmit, 1 receive |
| wr_data_i | input | 16 | Scale word |
| tx_sck_o | output | 1 | Transmit channel SCK level |
| tx_lead_o | output | 1 | Transmit leading-edge strobe |
| tx_trail_o | output | 1 | Transmit trailing-edge strobe |
| rx_sck_o | output | 1 | Receive channel SCK level |
| rx_lead_o | output | 1 | Receive leading-edge strobe |
| rx_trail_o | output | 1 | Receive trailing-edge strobe |

## Verification
The strobe-level assertions assume the polarity input is held steady while the enable is high. The bench changes polarity only after the enable has been low for several cycles. The scale-hold and counter-bound assertions assume the active scale word changes only at a boundary or while disabled, so the bench may write at any time but checks a half-period's length only once two toggles have passed since the write. Inputs change at the falling clock edge, so each enable or write reaches the design as a clean sample at the next rising edge.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;

    // Field layout of the scale word (fixed by software)
    localparam int SCALE_W   = 16;
    localparam int MULT_W    = 5;
    localparam int SHIFT_W   = 3;
    localparam int MULT_LSB  = 8;
    localparam int SHIFT_LSB = 0;

    // Largest power-of-two exponent and the bypass code
    localparam logic [SHIFT_W-1:0] SHIFT_TOP    = 3'd4;
    localparam logic [SHIFT_W-1:0] SHIFT_BYPASS = 3'd7;

    // Power counter must hold 2^SHIFT_TOP - 1 and the shifted one
    localparam int POW_W = 5;

    typedef struct packed {
        logic [MULT_W-1:0]  mult;
        logic [SHIFT_W-1:0] shift;
    } scale_t;

    function automatic scale_t unpack_scale(input logic [SCALE_W-1:0] word);
        scale_t s;
        s.mult  = word[MULT_LSB +: MULT_W];
        s.shift = word[SHIFT_LSB +: SHIFT_W];
        return s;
    endfunction

    // Reserved codes fold onto the largest legal exponent
    function automatic logic [SHIFT_W-1:0] fold_shift(input logic [SHIFT_W-1:0] code);
        logic [SHIFT_W-1:0] r;
        if (code > SHIFT_TOP && code != SHIFT_BYPASS) r = SHIFT_TOP;
        else                                           r = code;
        return r;
    endfunction

endpackage

// File: rtl/scale_hold.sv
module scale_hold
    import spi_baud_pkg::*;
#(
    parameter logic [SCALE_W-1:0] RESET_SCALE = 16'h0004
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [SCALE_W-1:0] wdata_i,
    input  logic               load_i,
    output scale_t             act_o
);

    typedef struct packed {
        scale_t pend;
        scale_t act;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i)   st_d.pend = unpack_scale(wdata_i);
        if (load_i) st_d.act  = st_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= unpack_scale(RESET_SCALE);
            st_q.act  <= unpack_scale(RESET_SCALE);
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o = st_q.act;

endmodule

// File: rtl/baud_timer.sv
module baud_timer
    import spi_baud_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en_i,
    input  logic   cpol_i,
    input  scale_t scale_i,
    output logic   sck_o,
    output logic   lead_o,
    output logic   trail_o,
    output logic   bound_o
);

    typedef struct packed {
        logic [MULT_W-1:0] mult_cnt;
        logic [POW_W-1:0]  pow_cnt;
        logic              sck;
        logic              lead;
        logic              trail;
    } timer_st_t;

    timer_st_t st_d, st_q;

    logic [SHIFT_W-1:0] shift_eff;
    logic               bypass;
    logic [POW_W-1:0]   pow_max;
    logic               mult_end;
    logic               pow_end;
    logic               terminal;

    always_comb begin
        shift_eff = fold_shift(scale_i.shift);
        bypass    = (scale_i.shift == SHIFT_BYPASS);
        pow_max   = bypass ? '0 : ((POW_W'(1) << shift_eff) - POW_W'(1));
        mult_end  = bypass || (st_q.mult_cnt == scale_i.mult);
        pow_end   = bypass || (st_q.pow_cnt == pow_max);
        terminal  = mult_end && pow_end;

        st_d       = st_q;
        st_d.lead  = 1'b0;
        st_d.trail = 1'b0;
        if (!en_i) begin
            st_d.mult_cnt = '0;
            st_d.pow_cnt  = '0;
            st_d.sck      = cpol_i;
        end else if (terminal) begin
            st_d.mult_cnt = '0;
            st_d.pow_cnt  = '0;
            st_d.sck      = ~st_q.sck;
            st_d.lead     = (st_q.sck == cpol_i);
            st_d.trail    = (st_q.sck != cpol_i);
        end else if (mult_end) begin
            st_d.mult_cnt = '0;
            st_d.pow_cnt  = st_q.pow_cnt + POW_W'(1);
        end else begin
            st_d.mult_cnt = st_q.mult_cnt + MULT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sck_o   = st_q.sck;
    assign lead_o  = st_q.lead;
    assign trail_o = st_q.trail;
    assign bound_o = en_i && terminal;

    // R6: disabled clock parks at the idle level with no strobes
    assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (sck_o == $past(cpol_i)) && !lead_o && !trail_o);

    // R7: strobes are mutually exclusive
    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lead_o, trail_o}));

    // R7: strobe kind matches the level SCK moved to
    assert_lead_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lead_o |-> (sck_o != cpol_i));
    assert_trail_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trail_o |-> (sck_o == cpol_i));

    // R7: every enabled SCK change carries a strobe
    assert_toggle_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && (sck_o != $past(sck_o))) |-> (lead_o || trail_o));

    // R3: counters never run past the active scale
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> (st_q.pow_cnt <= pow_max) && (bypass || st_q.mult_cnt <= scale_i.mult));

endmodule

// File: rtl/spi_baud_div.sv
module spi_baud_div
    import spi_baud_pkg::*;
#(
    parameter logic [15:0] RESET_SCALE = 16'h0004
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sck_en_i,
    input  logic        cpol_i,
    input  logic        wr_en_i,
    input  logic        wr_sel_i,
    input  logic [15:0] wr_data_i,
    output logic        tx_sck_o,
    output logic        tx_lead_o,
    output logic        tx_trail_o,
    output logic        rx_sck_o,
    output logic        rx_lead_o,
    output logic        rx_trail_o
);

    localparam int NUM_CH = 2;
    localparam int CH_TX  = 0;
    localparam int CH_RX  = 1;

    scale_t act_w   [NUM_CH];
    logic   sck_w   [NUM_CH];
    logic   lead_w  [NUM_CH];
    logic   trail_w [NUM_CH];
    logic   bound_w [NUM_CH];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        logic wr_hit;
        logic load;

        assign wr_hit = wr_en_i && (wr_sel_i == 1'(ch));
        assign load   = bound_w[ch] || !sck_en_i;

        scale_hold #(
            .RESET_SCALE (RESET_SCALE)
        ) u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (wr_hit),
            .wdata_i (wr_data_i),
            .load_i  (load),
            .act_o   (act_w[ch])
        );

        baud_timer u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (sck_en_i),
            .cpol_i  (cpol_i),
            .scale_i (act_w[ch]),
            .sck_o   (sck_w[ch]),
            .lead_o  (lead_w[ch]),
            .trail_o (trail_w[ch]),
            .bound_o (bound_w[ch])
        );

        // R9: active scale stays put inside a running half-period
        assert_hold_scale_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (sck_en_i && !bound_w[ch]) |=> $stable(act_w[ch]));
    end

    assign tx_sck_o   = sck_w[CH_TX];
    assign tx_lead_o  = lead_w[CH_TX];
    assign tx_trail_o = trail_w[CH_TX];
    assign rx_sck_o   = sck_w[CH_RX];
    assign rx_lead_o  = lead_w[CH_RX];
    assign rx_trail_o = trail_w[CH_RX];

endmodule

// File: tb/spi_baud_div_tb.sv
module spi_baud_div_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck_en = 1'b0;
    logic        cpol = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        tx_sck, tx_lead, tx_trail, rx_sck, rx_lead, rx_trail;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_baud_div u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_en_i   (sck_en),
        .cpol_i     (cpol),
        .wr_en_i    (wr_en),
        .wr_sel_i   (wr_sel),
        .wr_data_i  (wr_data),
        .tx_sck_o   (tx_sck),
        .tx_lead_o  (tx_lead),
        .tx_trail_o (tx_trail),
        .rx_sck_o   (rx_sck),
        .rx_lead_o  (rx_lead),
        .rx_trail_o (rx_trail)
    );

    function automatic logic sck_of(input int ch);
        return (ch == 0) ? tx_sck : rx_sck;
    endfunction
    function automatic logic lead_of(input int ch);
        return (ch == 0) ? tx_lead : rx_lead;
    endfunction
    function automatic logic trail_of(input int ch);
        return (ch == 0) ? tx_trail : rx_trail;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_scale(input bit sel, input logic [15:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // wait for the next SCK change on a channel
    task automatic wait_toggle(input int ch);
        logic prev;
        prev = sck_of(ch);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (sck_of(ch) != prev) break;
        end
    endtask

    // skip two toggles, then time several half-periods and their strobes
    task automatic measure(input int ch, input int exp_h, input int halves, input string req);
        wait_toggle(ch);
        wait_toggle(ch);
        for (int h = 0; h < halves; h++) begin
            int  len;
            bit  stray;
            logic prev;
            bit  exp_lead;
            len   = 0;
            stray = 1'b0;
            prev  = sck_of(ch);
            for (int i = 0; i < 5000; i++) begin
                @(negedge clk);
                len++;
                if (sck_of(ch) != prev) break;
                if (lead_of(ch) || trail_of(ch)) stray = 1'b1;
            end
            chk(len == exp_h, req, len, exp_h);
            exp_lead = (sck_of(ch) != cpol);
            // R7: strobe kind at the toggle, none in between
            chk(!stray && lead_of(ch) == exp_lead && trail_of(ch) == !exp_lead, "R7",
                {lead_of(ch), trail_of(ch)}, {exp_lead, !exp_lead});
        end
    endtask

    task automatic t_reset();
        repeat (2) @(negedge clk);
        chk(tx_sck == cpol && rx_sck == cpol, "R1", {tx_sck, rx_sck}, {cpol, cpol});
        chk({tx_lead, tx_trail, rx_lead, rx_trail} == 4'b0, "R1",
            {tx_lead, tx_trail, rx_lead, rx_trail}, 0);
    endtask

    task automatic t_enable();
        int cnt;
        sck_en = 1'b0;
        write_scale(1'b0, 16'h0200);          // mult 2, code 0: half = 3
        repeat (3) @(negedge clk);
        sck_en = 1'b1;
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            cnt++;
            if (tx_sck != cpol) break;
        end
        chk(cnt == 3, "R6", cnt, 3);
        @(negedge clk);
        sck_en = 1'b0;
        @(negedge clk);
        chk(tx_sck == cpol && !tx_lead && !tx_trail, "R6", tx_sck, cpol);
        repeat (5) @(negedge clk);
        chk(tx_sck == cpol && !tx_lead && !tx_trail && rx_sck == cpol, "R6", tx_sck, cpol);
    endtask

    task automatic t_ratios();
        sck_en = 1'b1;
        write_scale(1'b0, 16'h0000); measure(0, 1, 4, "R3");
        write_scale(1'b0, 16'h0003); measure(0, 8, 4, "R3");
        write_scale(1'b0, 16'h0401); measure(0, 10, 4, "R3");
        write_scale(1'b0, 16'h1F04); measure(0, 512, 2, "R3");
        write_scale(1'b0, 16'h0203); measure(0, 24, 4, "R11");
    endtask

    task automatic t_bypass();
        write_scale(1'b0, 16'h1F07); measure(0, 1, 6, "R4");
        write_scale(1'b0, 16'h1F00); measure(0, 32, 2, "R4");
    endtask

    task automatic t_reserved();
        write_scale(1'b0, 16'h0005); measure(0, 16, 2, "R5");
        write_scale(1'b0, 16'h0106); measure(0, 32, 2, "R5");
    endtask

    task automatic t_fields();
        // bits 15:13 and 7:3 set: must be ignored, mult 1 code 1 -> half 4
        write_scale(1'b0, 16'hE1F9); measure(0, 4, 4, "R2");
        write_scale(1'b1, 16'h0002); measure(1, 4, 2, "R2");
    endtask

    task automatic t_update();
        int len;
        logic prev;
        write_scale(1'b0, 16'h0004);          // half 16
        wait_toggle(0);
        wait_toggle(0);
        len = 0;
        repeat (5) begin @(negedge clk); len++; end
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h0100;   // half 2
        @(negedge clk); len++;
        wr_en = 1'b0;
        prev = tx_sck;
        for (int i = 0; i < 100; i++) begin
            if (tx_sck != prev) break;
            @(negedge clk); len++;
        end
        chk(len == 16, "R9", len, 16);
        len = 0;
        prev = tx_sck;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); len++;
            if (tx_sck != prev) break;
        end
        chk(len == 2, "R9", len, 2);
    endtask

    task automatic t_indep();
        write_scale(1'b0, 16'h0001);          // tx half 2
        write_scale(1'b1, 16'h0200);          // rx half 3
        measure(0, 2, 4, "R10");
        measure(1, 3, 4, "R10");
        write_scale(1'b1, 16'h0003);
        measure(0, 2, 2, "R10");
        measure(1, 8, 2, "R10");
    endtask

    task automatic t_polarity();
        sck_en = 1'b0;
        repeat (3) @(negedge clk);
        cpol = 1'b1;
        repeat (2) @(negedge clk);
        chk(tx_sck == 1'b1 && rx_sck == 1'b1, "R8", {tx_sck, rx_sck}, 3);
        write_scale(1'b0, 16'h0002);          // half 4
        sck_en = 1'b1;
        wait_toggle(0);
        chk(tx_sck == 1'b0 && tx_lead && !tx_trail, "R8", {tx_sck, tx_lead}, 1);
        measure(0, 4, 4, "R8");
        sck_en = 1'b0;
        repeat (3) @(negedge clk);
        cpol = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_ratios();
        t_bypass();
        t_reserved();
        t_fields();
        t_update();
        t_indep();
        t_polarity();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule